// File: doc/BRIEF.md
# Execute-Stage Instruction Decoder with Immediate Generator

This block turns one 32-bit instruction word from a small fixed RISC-V integer subset into everything the execute stage needs in order to run it: the three register indices, an immediate sign-extended to the datapath width, an ALU operation code, and datapath steering controls. The steering controls are a register write enable, the second-operand source, the write-back source, a memory write enable, the load size, the branch kind and the jump kind. It is purely combinational and sits between the instruction register and the execute datapath.

Only the opcode/funct combinations listed below are accepted. Every other combination, including the all-zero word that the pipeline injects to squash a fetched instruction, decodes to a bubble that changes no state. Writes aimed at register zero are dropped at the decoder, so the register file never sees them.

Top module: `rv_exec_decoder`

## Requirements
- R1: `rs1_idx`, `rs2_idx` and `rd_idx` always equal instruction bits [19:15], [24:20] and [11:7], whatever the opcode.
- R2: `imm` is the I-format immediate for opcodes 0x03, 0x13 and 0x67, the S-format immediate for 0x23, the B-format immediate (bit 0 zero) for 0x63, bits [31:12] followed by twelve zero bits for 0x37, and the J-format immediate (bit 0 zero) for 0x6f, each in standard RISC-V bit order and sign-extended from instruction bit 31; it is zero for opcode 0x33 and for every rejected word.
- R3: Opcode 0x33 writes the ALU result (`wb_sel`=0, `opb_imm`=0) with `alu_op` ADD=0, SLL=2, SLT=3, XOR=4, SRL=5, OR=7, AND=8 for funct7 0x00 and funct3 0,1,2,4,5,6,7; MUL=9, MULH=10, DIV=11, REM=12 for funct7 0x01 and funct3 0,1,4,6; SUB=1 for funct7 0x20 with funct3 0.
- R4: Opcode 0x13 writes the ALU result with `opb_imm`=1 and `alu_op` ADD, SLT, XOR, OR, AND for funct3 0, 2, 4, 6, 7 (any funct7); SLL for funct3 1 only with funct7 0x00; SRL (5) for funct3 5 with funct7 0x00 and SRA (6) with funct7 0x20; funct3 3 is rejected.
- R5: Opcode 0x03 with funct3 0, 1, 2 sets `ld_size` 0 (signed byte), 1 (signed half), 2 (word), `wb_sel`=1, `opb_imm`=1, `alu_op`=ADD; `ld_size` is 3 for every other word.
- R6: Opcode 0x23 is accepted only with funct3 2 and then sets `mem_we`=1, `opb_imm`=1, `alu_op`=ADD and no register write.
- R7: Opcode 0x63 sets `br_kind` 1 (equal), 2 (not equal), 3 (signed less), 4 (unsigned less) for funct3 0, 1, 4, 6, with `alu_op`=SUB, `opb_imm`=0 and no register write; other funct3 values are rejected.
- R8: Opcode 0x37 writes the upper immediate (`wb_sel`=3) with `opb_imm`=0 and `alu_op`=ADD.
- R9: Opcode 0x6f sets `jmp_kind`=1; opcode 0x67 with funct3 0 sets `jmp_kind`=2, `opb_imm`=1, `alu_op`=ADD; both write PC+4 (`wb_sel`=2).
- R10: The word 0x00000000, any opcode not listed above, and any unlisted funct combination give `reg_we`=0, `mem_we`=0, `br_kind`=0, `jmp_kind`=0, `alu_op`=0, `wb_sel`=0, `opb_imm`=0, `ld_size`=3 and `imm`=0.
- R11: `reg_we` is 0 whenever `rd_idx` is zero, even for a word that would otherwise write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word in the execute stage |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| rd_idx | output | 5 | Destination register index |
| imm | output | XLEN (32) | Sign-extended immediate |
| alu_op | output | 4 | ALU operation code |
| reg_we | output | 1 | Register file write enable |
| opb_imm | output | 1 | Second ALU operand is the immediate (1) or rs2 (0) |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4, 3 upper immediate |
| mem_we | output | 1 | Data memory write enable |
| ld_size | output | 2 | Load size: 0 byte, 1 half, 2 word, 3 no load |
| br_kind | output | 3 | Branch condition: 0 none, 1 eq, 2 ne, 3 lt, 4 ltu |
| jmp_kind | output | 2 | Jump: 0 none, 1 PC-relative, 2 register-based |

## Verification
The sweep crosses all 128 opcodes with every funct3, four funct7 values and both a zero and a non-zero destination, so near-miss encodings such as a shift-immediate with funct7 0x01, an unsigned set-less-than, a store of byte size or a jalr with non-zero funct3 are all hit; a decoder that matched on opcode alone would write registers or memory for them. A one-hot bit walk over instruction bits 7 to 31 for each immediate format exposes any scrambled or swapped immediate bit, and a missing sign extension shows up as wrong upper bits whenever bit 31 is set. Words with destination zero catch a decoder that lets the write enable through to x0.

// File: rtl/dec_pkg.sv
`timescale 1ns/1ps
package dec_pkg;

  localparam int ILEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [6:0] OPC_REG   = 7'h33;
  localparam logic [6:0] OPC_LOAD  = 7'h03;
  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_STORE = 7'h23;
  localparam logic [6:0] OPC_BR    = 7'h63;
  localparam logic [6:0] OPC_LUI   = 7'h37;
  localparam logic [6:0] OPC_JAL   = 7'h6f;
  localparam logic [6:0] OPC_JALR  = 7'h67;

  typedef enum logic [2:0] {
    FMT_NONE, FMT_I, FMT_S, FMT_B, FMT_U, FMT_J
  } imm_fmt_e;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,  ALU_SUB = 4'd1,  ALU_SLL = 4'd2,  ALU_SLT  = 4'd3,
    ALU_XOR  = 4'd4,  ALU_SRL = 4'd5,  ALU_SRA = 4'd6,  ALU_OR   = 4'd7,
    ALU_AND  = 4'd8,  ALU_MUL = 4'd9,  ALU_MULH = 4'd10, ALU_DIV = 4'd11,
    ALU_REM  = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC4, WB_UIMM} wb_sel_e;
  typedef enum logic [1:0] {LD_BYTE, LD_HALF, LD_WORD, LD_NONE} ld_size_e;
  typedef enum logic [2:0] {BR_NONE, BR_EQ, BR_NE, BR_LT, BR_LTU} br_kind_e;
  typedef enum logic [1:0] {JMP_NONE, JMP_PCREL, JMP_REG} jmp_kind_e;

endpackage

// File: rtl/dec_alusel.sv
`timescale 1ns/1ps
module dec_alusel
  import dec_pkg::*;
(
  input  logic       is_reg,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output alu_op_e    op,
  output logic       ok
);

  always_comb begin
    op = ALU_ADD;
    ok = 1'b0;
    if (is_reg) begin
      unique case (funct7)
        7'h00: begin
          ok = 1'b1;
          case (funct3)
            3'd0: op = ALU_ADD;
            3'd1: op = ALU_SLL;
            3'd2: op = ALU_SLT;
            3'd4: op = ALU_XOR;
            3'd5: op = ALU_SRL;
            3'd6: op = ALU_OR;
            3'd7: op = ALU_AND;
            default: ok = 1'b0;
          endcase
        end
        7'h01: begin
          ok = 1'b1;
          case (funct3)
            3'd0: op = ALU_MUL;
            3'd1: op = ALU_MULH;
            3'd4: op = ALU_DIV;
            3'd6: op = ALU_REM;
            default: ok = 1'b0;
          endcase
        end
        7'h20: begin
          ok = (funct3 == 3'd0);
          op = ALU_SUB;
        end
        default: ok = 1'b0;
      endcase
    end else begin
      ok = 1'b1;
      case (funct3)
        3'd0: op = ALU_ADD;
        3'd2: op = ALU_SLT;
        3'd4: op = ALU_XOR;
        3'd6: op = ALU_OR;
        3'd7: op = ALU_AND;
        3'd1: begin
          op = ALU_SLL;
          ok = (funct7 == 7'h00);
        end
        3'd5: begin
          if (funct7 == 7'h00)      op = ALU_SRL;
          else if (funct7 == 7'h20) op = ALU_SRA;
          else                      ok = 1'b0;
        end
        default: ok = 1'b0;
      endcase
    end
    if (!ok) op = ALU_ADD;
  end

endmodule

// File: rtl/dec_immgen.sv
`timescale 1ns/1ps
module dec_immgen
  import dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:7] ibits,
  input  imm_fmt_e        fmt,
  output logic [XLEN-1:0] imm
);

  logic        s;
  logic [31:0] raw;

  assign s = ibits[31];

  always_comb begin
    unique case (fmt)
      FMT_I:   raw = {{20{s}}, ibits[31:20]};
      FMT_S:   raw = {{20{s}}, ibits[31:25], ibits[11:7]};
      FMT_B:   raw = {{19{s}}, s, ibits[7], ibits[30:25], ibits[11:8], 1'b0};
      FMT_U:   raw = {ibits[31:12], 12'd0};
      FMT_J:   raw = {{11{s}}, s, ibits[19:12], ibits[20], ibits[30:21], 1'b0};
      default: raw = 32'd0;
    endcase
  end

  generate
    if (XLEN > 32) begin : g_wide
      assign imm = {{(XLEN-32){raw[31]}}, raw};
    end else begin : g_narrow
      assign imm = raw;
    end
  endgenerate

endmodule

// File: rtl/dec_ctrl.sv
`timescale 1ns/1ps
module dec_ctrl
  import dec_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  input  logic       rd_zero,
  output imm_fmt_e   fmt,
  output alu_op_e    alu_op,
  output logic       reg_we,
  output logic       opb_imm,
  output wb_sel_e    wb_sel,
  output logic       mem_we,
  output ld_size_e   ld_size,
  output br_kind_e   br_kind,
  output jmp_kind_e  jmp_kind
);

  alu_op_e sel_op;
  logic    sel_ok;
  logic    wr;

  dec_alusel u_alusel (
    .is_reg (opcode == OPC_REG),
    .funct3 (funct3),
    .funct7 (funct7),
    .op     (sel_op),
    .ok     (sel_ok)
  );

  always_comb begin
    fmt      = FMT_NONE;
    alu_op   = ALU_ADD;
    wr       = 1'b0;
    opb_imm  = 1'b0;
    wb_sel   = WB_ALU;
    mem_we   = 1'b0;
    ld_size  = LD_NONE;
    br_kind  = BR_NONE;
    jmp_kind = JMP_NONE;
    case (opcode)
      OPC_REG: if (sel_ok) begin
        alu_op = sel_op;
        wr     = 1'b1;
      end
      OPC_IMM: if (sel_ok) begin
        alu_op  = sel_op;
        wr      = 1'b1;
        opb_imm = 1'b1;
        fmt     = FMT_I;
      end
      OPC_LOAD: if (funct3 < 3'd3) begin
        wr      = 1'b1;
        opb_imm = 1'b1;
        wb_sel  = WB_MEM;
        ld_size = ld_size_e'(funct3[1:0]);
        fmt     = FMT_I;
      end
      OPC_STORE: if (funct3 == 3'd2) begin
        mem_we  = 1'b1;
        opb_imm = 1'b1;
        fmt     = FMT_S;
      end
      OPC_BR: begin
        case (funct3)
          3'd0: br_kind = BR_EQ;
          3'd1: br_kind = BR_NE;
          3'd4: br_kind = BR_LT;
          3'd6: br_kind = BR_LTU;
          default: br_kind = BR_NONE;
        endcase
        if (br_kind != BR_NONE) begin
          alu_op = ALU_SUB;
          fmt    = FMT_B;
        end
      end
      OPC_LUI: begin
        wr     = 1'b1;
        wb_sel = WB_UIMM;
        fmt    = FMT_U;
      end
      OPC_JAL: begin
        wr       = 1'b1;
        wb_sel   = WB_PC4;
        jmp_kind = JMP_PCREL;
        fmt      = FMT_J;
      end
      OPC_JALR: if (funct3 == 3'd0) begin
        wr       = 1'b1;
        wb_sel   = WB_PC4;
        jmp_kind = JMP_REG;
        opb_imm  = 1'b1;
        fmt      = FMT_I;
      end
      default: ;
    endcase
  end

  // R11: destination zero never reaches the register file
  assign reg_we = wr & ~rd_zero;

endmodule

// File: rtl/rv_exec_decoder.sv
`timescale 1ns/1ps
module rv_exec_decoder
  import dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output logic [4:0]      rs1_idx,
  output logic [4:0]      rs2_idx,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] imm,
  output logic [3:0]      alu_op,
  output logic            reg_we,
  output logic            opb_imm,
  output logic [1:0]      wb_sel,
  output logic            mem_we,
  output logic [1:0]      ld_size,
  output logic [2:0]      br_kind,
  output logic [1:0]      jmp_kind
);

  imm_fmt_e  fmt;
  alu_op_e   c_alu;
  wb_sel_e   c_wb;
  ld_size_e  c_ld;
  br_kind_e  c_br;
  jmp_kind_e c_jmp;

  assign rs1_idx = instr[19:15];
  assign rs2_idx = instr[24:20];
  assign rd_idx  = instr[11:7];

  dec_ctrl u_ctrl (
    .opcode   (instr[6:0]),
    .funct3   (instr[14:12]),
    .funct7   (instr[31:25]),
    .rd_zero  (instr[11:7] == 5'd0),
    .fmt      (fmt),
    .alu_op   (c_alu),
    .reg_we   (reg_we),
    .opb_imm  (opb_imm),
    .wb_sel   (c_wb),
    .mem_we   (mem_we),
    .ld_size  (c_ld),
    .br_kind  (c_br),
    .jmp_kind (c_jmp)
  );

  dec_immgen #(.XLEN(XLEN)) u_imm (
    .ibits (instr[31:7]),
    .fmt   (fmt),
    .imm   (imm)
  );

  assign alu_op   = c_alu;
  assign wb_sel   = c_wb;
  assign ld_size  = c_ld;
  assign br_kind  = c_br;
  assign jmp_kind = c_jmp;

  always_comb begin
    a_r11_no_x0_write: assert (!(reg_we && rd_idx == 5'd0))
      else $error("register write enabled for x0");
    a_r10_one_effect: assert ($countones({reg_we, mem_we, br_kind != 3'd0}) <= 1)
      else $error("more than one state-changing effect");
    a_r6_store_uses_imm: assert (!mem_we || (opb_imm && imm[XLEN-1:12] == {(XLEN-12){instr[31]}}))
      else $error("store without sign-extended immediate operand");
    a_r7_branch_even: assert (br_kind == 3'd0 || (imm[0] == 1'b0 && !opb_imm))
      else $error("branch offset odd or immediate operand selected");
    a_r9_jump_links: assert (jmp_kind == 2'd0 || wb_sel == 2'd2)
      else $error("jump without PC+4 write-back");
    a_r5_load_size: assert ((wb_sel == 2'd1) == (ld_size != 2'd3))
      else $error("load size inconsistent with memory write-back");
  end

endmodule

// File: tb/sim_rv_exec_decoder.sv
`timescale 1ns/1ps
module sim_rv_exec_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic [31:0] imm;
  logic [3:0]  alu_op;
  logic        reg_we, opb_imm, mem_we;
  logic [1:0]  wb_sel, ld_size, jmp_kind;
  logic [2:0]  br_kind;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] lfsr = 32'h1d2c_3b4a;

  always #2.5 clk = ~clk;

  rv_exec_decoder #(.XLEN(32)) u0 (
    .instr(instr), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
    .imm(imm), .alu_op(alu_op), .reg_we(reg_we), .opb_imm(opb_imm),
    .wb_sel(wb_sel), .mem_we(mem_we), .ld_size(ld_size),
    .br_kind(br_kind), .jmp_kind(jmp_kind)
  );

  function automatic logic [31:0] step(input logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // Expected values from the requirements; controls packed as
  // {alu4, we, opb, wb2, mwe, ld2, br3, jmp2}
  task automatic model(input logic [31:0] w, output logic [15:0] c,
                       output logic [31:0] im, output string tg);
    logic [6:0] op;
    logic [2:0] f3;
    logic [6:0] f7;
    int alu, iv;
    bit wr, opb, mwe, ok;
    int wb, ld, br, jp;
    op = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
    alu = 0; wr = 0; opb = 0; mwe = 0; ok = 0;
    wb = 0; ld = 3; br = 0; jp = 0; im = 32'd0; tg = "R10";
    case (op)
      7'h33: begin
        if (f7 == 7'h00 && f3 != 3'd3) begin
          ok = 1;
          case (f3) 3'd0: alu = 0; 3'd1: alu = 2; 3'd2: alu = 3; 3'd4: alu = 4;
                    3'd5: alu = 5; 3'd6: alu = 7; default: alu = 8; endcase
        end else if (f7 == 7'h01 && (f3 == 0 || f3 == 1 || f3 == 4 || f3 == 6)) begin
          ok = 1;
          case (f3) 3'd0: alu = 9; 3'd1: alu = 10; 3'd4: alu = 11; default: alu = 12; endcase
        end else if (f7 == 7'h20 && f3 == 3'd0) begin
          ok = 1; alu = 1;
        end
        if (ok) begin wr = 1; tg = "R3"; end
      end
      7'h13: begin
        case (f3)
          3'd0: begin ok = 1; alu = 0; end
          3'd2: begin ok = 1; alu = 3; end
          3'd4: begin ok = 1; alu = 4; end
          3'd6: begin ok = 1; alu = 7; end
          3'd7: begin ok = 1; alu = 8; end
          3'd1: if (f7 == 7'h00) begin ok = 1; alu = 2; end
          3'd5: if (f7 == 7'h00) begin ok = 1; alu = 5; end
                else if (f7 == 7'h20) begin ok = 1; alu = 6; end
          default: ok = 0;
        endcase
        if (ok) begin
          wr = 1; opb = 1; tg = "R4";
          iv = int'(w[31:20]) - (w[31] ? 4096 : 0); im = 32'(iv);
        end
      end
      7'h03: if (f3 <= 3'd2) begin
        wr = 1; opb = 1; wb = 1; ld = int'(f3); tg = "R5";
        iv = int'(w[31:20]) - (w[31] ? 4096 : 0); im = 32'(iv);
      end
      7'h23: if (f3 == 3'd2) begin
        mwe = 1; opb = 1; tg = "R6";
        iv = int'(w[31:25]) * 32 + int'(w[11:7]) - (w[31] ? 4096 : 0); im = 32'(iv);
      end
      7'h63: begin
        case (f3) 3'd0: br = 1; 3'd1: br = 2; 3'd4: br = 3; 3'd6: br = 4; default: br = 0; endcase
        if (br != 0) begin
          alu = 1; tg = "R7";
          iv = int'(w[7]) * 2048 + int'(w[30:25]) * 32 + int'(w[11:8]) * 2 - (w[31] ? 4096 : 0);
          im = 32'(iv);
        end
      end
      7'h37: begin
        wr = 1; wb = 3; tg = "R8"; im = w & 32'hffff_f000;
      end
      7'h6f: begin
        wr = 1; wb = 2; jp = 1; tg = "R9";
        iv = int'(w[19:12]) * 4096 + int'(w[20]) * 2048 + int'(w[30:21]) * 2
             - (w[31] ? 1048576 : 0);
        im = 32'(iv);
      end
      7'h67: if (f3 == 3'd0) begin
        wr = 1; wb = 2; jp = 2; opb = 1; tg = "R9";
        iv = int'(w[31:20]) - (w[31] ? 4096 : 0); im = 32'(iv);
      end
      default: ;
    endcase
    c = {4'(alu), wr && (w[11:7] != 5'd0), opb, 2'(wb), mwe, 2'(ld), 3'(br), 2'(jp)};
  endtask

  task automatic check(input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: instr %h actual %h expected %h", tg, instr, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    logic [15:0] ec;
    logic [31:0] ei;
    string tg;
    @(posedge clk);
    instr <= w;
    @(negedge clk);
    model(w, ec, ei, tg);
    check("R1", {17'd0, rs1_idx, rs2_idx, rd_idx}, {17'd0, w[19:15], w[24:20], w[11:7]});
    check("R2", imm, ei);
    check(tg, {16'd0, alu_op, reg_we, opb_imm, wb_sel, mem_we, ld_size, br_kind, jmp_kind},
          {16'd0, ec});
    if (w[11:7] == 5'd0) check("R11", {31'd0, reg_we}, 32'd0);
  endtask

  initial begin
    logic [6:0] f7s [4];
    f7s[0] = 7'h00; f7s[1] = 7'h01; f7s[2] = 7'h20; f7s[3] = 7'h7f;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero word is a bubble (R10)
    @(negedge clk);
    check("R10", {16'd0, alu_op, reg_we, opb_imm, wb_sel, mem_we, ld_size, br_kind, jmp_kind},
          {16'd0, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd3, 3'd0, 2'd0});
    check("R10", imm, 32'd0);
    apply(32'd0);
    // full opcode x funct sweep
    for (int op = 0; op < 128; op++)
      for (int f3 = 0; f3 < 8; f3++)
        for (int k = 0; k < 4; k++)
          for (int z = 0; z < 2; z++) begin
            lfsr = step(lfsr);
            apply({f7s[k], lfsr[24:15], 3'(f3), (z == 0) ? 5'd0 : (lfsr[4:0] | 5'd1), 7'(op)});
          end
    // one-hot walk over immediate bits for each format
    for (int s = 0; s < 6; s++)
      for (int b = 7; b < 32; b++) begin
        logic [6:0] opc;
        case (s) 0: opc = 7'h13; 1: opc = 7'h23; 2: opc = 7'h63;
                 3: opc = 7'h37; 4: opc = 7'h6f; default: opc = 7'h67; endcase
        apply((32'd1 << b) | {25'd0, opc});
        apply(~(32'd1 << b) & 32'hffff_ff80 | {25'd0, opc});
      end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule